// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block keeps an 8-bit count driven by a single input pin, in one of two modes. In event mode the count goes up once for each edge of the pin that a polarity bit selects. In gated mode a free-running divider turns the bus clock into a slow tick, one every 64 bus clocks. The count takes that tick only while the pin stays at its enabling level, so the count measures how long the pin stayed active.

The polarity bit means different things in the two modes. In event mode it picks the edge that counts. In gated mode it picks the pin level that stops the count. Two sticky flags report events: one marks the wrap of the count, and the other marks a pin edge. Each flag has its own interrupt enable, and both feed a single interrupt output. Software can load the count at any time and can read it at any time. The pin is taken to be synchronous to the bus clock already.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count is 0x00, both flags are clear, `irq_o` is low and the divider stands at zero.
- R2: In event mode (`gate_mode_i`=0) with the block enabled, the count goes up by one in the clock where the pin shows a falling edge if `pol_i`=0, or a rising edge if `pol_i`=1. An edge is the pin value differing from its value one clock earlier. The other edge direction leaves the count unchanged.
- R3: In gated mode (`gate_mode_i`=1) with the block enabled, the divider counts 0 to 63 from reset and then repeats. The count goes up by one only in the clock where the divider reads 63 and the pin is not at its stopping level. The stopping level is low for `pol_i`=0 and high for `pol_i`=1.
- R4: When an increment takes the count from 0xFF to 0x00, `ovf_flag_o` sets.
- R5: While the block is enabled, `edg_flag_o` sets on the falling edge of the pin for `pol_i`=0 and on the rising edge for `pol_i`=1, in either mode. In gated mode this is the edge into the stopping level.
- R6: While `en_i`=0 the count holds its value, except when software loads it, and neither flag sets.
- R7: A load (`cnt_we_i`=1) puts `cnt_wdata_i` into the count on the next clock whatever the mode or enable. It wins over an increment in the same clock, and that increment then neither happens nor sets the overflow flag.
- R8: `flag_clr_i[0]` clears the edge flag and `flag_clr_i[1]` clears the overflow flag. If a flag sets in the same clock as its clear, the flag stays set.
- R9: `irq_o` is high exactly when (`ovf_flag_o` and `ovf_ie_i`) or (`edg_flag_o` and `edg_ie_i`) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 1 | Counted input pin, synchronous to clk |
| en_i | input | 1 | Accumulator enable |
| gate_mode_i | input | 1 | 0 selects event counting, 1 selects gated time counting |
| pol_i | input | 1 | Edge select in event mode, stopping level in gated mode |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| edg_ie_i | input | 1 | Edge interrupt enable |
| cnt_we_i | input | 1 | Load strobe for the count |
| cnt_wdata_i | input | 8 | Value to load |
| flag_clr_i | input | 2 | Flag clear strobes: bit 0 edge, bit 1 overflow |
| cnt_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Overflow flag |
| edg_flag_o | output | 1 | Pin edge flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A stale previous-pin register shows up at once as a missed or extra increment, or a wrong edge flag, on the clock after the pin changes. A divider that is out of phase or has the wrong length shows up in gated mode as counts arriving in the wrong clock. That shows at the latest after 64 clocks and again on every tick after it. A wrong wrap test or a bad load priority shows up within one clock of the event, in the overflow flag and in `cnt_o`. The bench models the divider phase from reset, so every clock is checked against a known expected count.

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int W   = 8,
  parameter int DIV = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_i,
  input  logic         en_i,
  input  logic         gate_mode_i,
  input  logic         pol_i,
  input  logic         ovf_ie_i,
  input  logic         edg_ie_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic [1:0]   flag_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_flag_o,
  output logic         edg_flag_o,
  output logic         irq_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

  logic [PW-1:0] presc;
  logic          pin_d;
  logic [W-1:0]  cnt;
  logic          ovf_q, edg_q;

  wire tick      = (presc == PLAST);
  wire rise      = pin_i & ~pin_d;
  wire fall      = ~pin_i & pin_d;
  wire sel_edge  = pol_i ? rise : fall;
  wire gate_open = pin_i ^ pol_i;
  wire inc       = en_i & (gate_mode_i ? (tick & gate_open) : sel_edge);
  wire bump      = inc & ~cnt_we_i;
  wire wrap      = bump & (cnt == {W{1'b1}});
  wire edg_set   = en_i & sel_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      pin_d <= 1'b0;
    end else begin
      presc <= tick ? '0 : presc + 1'b1;
      pin_d <= pin_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt_we_i) cnt <= cnt_wdata_i;
    else if (bump)     cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      edg_q <= 1'b0;
    end else begin
      ovf_q <= wrap    | (ovf_q & ~flag_clr_i[1]);
      edg_q <= edg_set | (edg_q & ~flag_clr_i[0]);
    end
  end

  assign cnt_o      = cnt;
  assign ovf_flag_o = ovf_q;
  assign edg_flag_o = edg_q;
  assign irq_o      = (ovf_q & ovf_ie_i) | (edg_q & edg_ie_i);
endmodule

// File: rtl/pulse_accum_chk.sv
module pulse_accum_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic         ovf_ie_i,
  input logic         edg_ie_i,
  input logic         cnt_we_i,
  input logic [W-1:0] cnt_wdata_i,
  input logic [1:0]   flag_clr_i,
  input logic [W-1:0] cnt_o,
  input logic         ovf_flag_o,
  input logic         edg_flag_o,
  input logic         irq_o
);
  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> (cnt_o == $past(cnt_wdata_i)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !cnt_we_i) |=> $stable(cnt_o));

  // R6
  idle_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !ovf_flag_o && !edg_flag_o) |=> (!ovf_flag_o && !edg_flag_o));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we_i && cnt_o == {W{1'b1}} && !ovf_flag_o) |=>
      (cnt_o == {W{1'b1}} || (cnt_o == '0 && ovf_flag_o)));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i[1] && !(cnt_o == {W{1'b1}})) |=> !ovf_flag_o);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((ovf_flag_o && ovf_ie_i) || (edg_flag_o && edg_ie_i)) |-> !irq_o);
endmodule

bind pulse_accum pulse_accum_chk #(.W(W)) u_pulse_accum_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .ovf_ie_i(ovf_ie_i),
  .edg_ie_i(edg_ie_i), .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
  .flag_clr_i(flag_clr_i), .cnt_o(cnt_o), .ovf_flag_o(ovf_flag_o),
  .edg_flag_o(edg_flag_o), .irq_o(irq_o)
);

// File: tb/test_pulse_accum.sv
module test_pulse_accum;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, en = 1'b0, gm = 1'b0, pol = 1'b0, oie = 1'b0, eie = 1'b0, we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [1:0] clr = 2'b00;
  logic [7:0] cnt;
  logic       ovf, edg, irq;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_cnt = 8'h00;
  logic       m_ovf = 1'b0, m_edg = 1'b0, m_pin = 1'b0;
  int         m_div = 0;

  always #2 clk = ~clk;

  pulse_accum i_pulse_accum (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .en_i(en), .gate_mode_i(gm),
    .pol_i(pol), .ovf_ie_i(oie), .edg_ie_i(eie), .cnt_we_i(we),
    .cnt_wdata_i(wd), .flag_clr_i(clr), .cnt_o(cnt), .ovf_flag_o(ovf),
    .edg_flag_o(edg), .irq_o(irq)
  );

  function automatic logic counted_edge(logic p, logic prev, logic pl);
    return pl ? (p & ~prev) : (~p & prev);
  endfunction

  function automatic logic model_irq(logic o, logic e, logic oi, logic ei);
    return (o & oi) | (e & ei);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(string req);
    logic e, tick, inc;
    @(posedge clk);
    e    = counted_edge(pin, m_pin, pol);
    tick = (m_div == 63);
    inc  = en & (gm ? (tick & (pin ^ pol)) : e);
    if (we) m_cnt = wd;
    else if (inc) begin
      if (m_cnt == 8'hFF) m_ovf = 1'b1;
      else if (clr[1]) m_ovf = 1'b0;
      m_cnt = m_cnt + 8'd1;
    end
    if (we || !inc || m_cnt != 8'h00) if (clr[1] && !(inc && !we && m_cnt == 8'h00)) m_ovf = 1'b0;
    if (en & e) m_edg = 1'b1;
    else if (clr[0]) m_edg = 1'b0;
    m_pin = pin;
    m_div = tick ? 0 : m_div + 1;
    @(negedge clk);
    check({req, " count"}, 32'(cnt), 32'(m_cnt));
    check({req, " ovf"}, 32'(ovf), 32'(m_ovf));
    check({req, " edge"}, 32'(edg), 32'(m_edg));
    check("R9 irq", 32'(irq), 32'(model_irq(m_ovf, m_edg, oie, eie)));
    we  = 1'b0;
    clr = 2'b00;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 count", 32'(cnt), 32'h0);
    check("R1 ovf", 32'(ovf), 32'h0);
    check("R1 edge", 32'(edg), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 event mode, falling edges, pol=0
    en = 1'b1; gm = 1'b0; pol = 1'b0; eie = 1'b1;
    pin = 1'b1; step("R2 rise ignored");
    pin = 1'b0; step("R2 fall counts");
    check("R2 value", 32'(cnt), 32'h1);
    check("R5 edge set", 32'(edg), 32'h1);
    clr = 2'b01; step("R8 edge clear");
    check("R8 cleared", 32'(edg), 32'h0);

    // R7 load wins over counted edge, R4 overflow
    pol = 1'b1; pin = 1'b1; we = 1'b1; wd = 8'hFF; step("R7 load beats inc");
    check("R7 loaded", 32'(cnt), 32'hFF);
    pin = 1'b0; step("R2 fall ignored pol1");
    pin = 1'b1; step("R4 wrap");
    check("R4 zero", 32'(cnt), 32'h0);
    check("R4 flag", 32'(ovf), 32'h1);

    // R6 disabled hold
    en = 1'b0;
    pin = 1'b0; step("R6 hold");
    pin = 1'b1; step("R6 hold");
    check("R6 count held", 32'(cnt), 32'h0);

    // R3 gated mode, full divider periods
    en = 1'b1; gm = 1'b1; pol = 1'b0; pin = 1'b1; clr = 2'b11;
    repeat (200) step("R3 gated");
    pin = 1'b0;
    repeat (130) step("R3 gated stopped");

    // R8 set beats clear: wrap while clearing overflow
    gm = 1'b0; pol = 1'b0; pin = 1'b1; we = 1'b1; wd = 8'hFF; step("R7 load");
    pin = 1'b0; clr = 2'b11; step("R8 set wins");
    check("R8 ovf kept", 32'(ovf), 32'h1);
    check("R8 edge kept", 32'(edg), 32'h1);

    // random segments
    for (int s = 0; s < 60; s++) begin
      en  = ($urandom % 5) != 0;
      gm  = $urandom % 2;
      pol = $urandom % 2;
      oie = $urandom % 2;
      eie = $urandom % 2;
      for (int c = 0; c < 100; c++) begin
        if ($urandom % 4 == 0) pin = ~pin;
        if ($urandom % 25 == 0) begin
          we = 1'b1;
          wd = ($urandom % 2) ? 8'hFE : 8'($urandom);
        end
        if ($urandom % 10 == 0) clr = 2'($urandom);
        step(gm ? "R3 random" : "R2 random");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule